// File: doc/BRIEF.md
# Host Controller Interrupt Register Unit

This block keeps the pending-event flags and the enable mask of a USB host controller and turns them into a single level-sensitive interrupt line. Other parts of the controller, such as frame timing, list processing and the root hub, report events as one-cycle pulses on a small event vector. Each pulse latches a flag at a fixed bit position of a 32-bit status word. Software reads and acknowledges these flags over a simple word-addressed register bus.

The enable mask is reached through two aliases. One alias ORs ones into the mask and the other clears them, and both return the same mask when read. Bit 31 of the mask acts as a global gate, so the line can be silenced without losing the per-event enables. The interrupt output is registered, so it follows the register state one clock later.

Top module: `hc_irq_unit`

## Requirements
- R1: After reset the status word reads 0x00000000, the mask reads 0x80000000 (only the global gate, bit 31, set) and `irq` is low.
- R2: A pulse on `ev_pulse[i]` sets a status bit one clock later. Indices 0 to 6 map to bits 0 to 6: scheduling overrun, done-list writeback, frame start, resume detected, fatal error, frame counter wrap and hub change. Index 7 (ownership handover) maps to bit 30.
- R3: A write to address 0 (status) clears every status bit written as 1 and leaves every bit written as 0 unchanged.
- R4: When an event pulse and a status clear hit the same bit in the same cycle, the bit ends up set.
- R5: A write to address 1 (enable-set) ORs the written value into the mask.
- R6: A write to address 2 (enable-clear) clears every mask bit written as 1.
- R7: A read of address 1 and a read of address 2 both return the current mask. A read of address 0 returns the status word. `reg_rdata` is combinational from `reg_addr`.
- R8: `irq` is high when mask bit 31 is set and some status bit is also set in the mask. It takes this value one clock after the state that causes it.
- R9: Status bits other than 0 to 6 and 30, and mask bits other than 0 to 6, 30 and 31, always read 0. Address 3 reads 0, and writes to it change nothing.
- R10: With mask bit 31 clear, `irq` stays low even when an enabled status bit is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Bus access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read (qualified by reg_sel) |
| reg_addr | input | 2 | Word address: 0 status, 1 enable-set, 2 enable-clear |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| ev_pulse | input | 8 | One-cycle event pulses, mapping as in R2 |
| irq | output | 1 | Registered level interrupt |

## Verification
A write or an event pulse lands in the registers at the clock edge that samples it, so a register read taken at the following falling edge already shows it. The interrupt line is due one edge later still. The driver therefore checks `irq` twice after each mask or status change. The first check, at the falling edge just after the write, expects the old level. The second check, after one more edge, expects the new level. This pins the single-cycle latency of R8 and R10. Register reads are queued and compared half a period before the next rising edge, so they never overlap a state change.

// File: rtl/hc_irq_pkg.sv
package hc_irq_pkg;

    localparam int HC_DW         = 32;
    localparam int HC_AW         = 2;
    localparam int HC_NUM_EV     = 8;
    localparam int HC_GATE_POS   = 31;
    localparam int HC_HANDOVER_P = 30;

    typedef enum logic [HC_AW-1:0] {
        HC_A_STATUS = 2'd0,
        HC_A_EN_SET = 2'd1,
        HC_A_EN_CLR = 2'd2,
        HC_A_SPARE  = 2'd3
    } hc_reg_e;

    // Event index to status bit position
    function automatic int ev_bit_pos(input int idx);
        if (idx == HC_NUM_EV - 1) return HC_HANDOVER_P;
        return idx;
    endfunction

    // Spread an event vector onto its status positions
    function automatic logic [HC_DW-1:0] ev_spread(input logic [HC_NUM_EV-1:0] ev);
        logic [HC_DW-1:0] r;
        r = '0;
        for (int i = 0; i < HC_NUM_EV; i++) begin
            r[ev_bit_pos(i)] = ev[i];
        end
        return r;
    endfunction

    localparam logic [HC_DW-1:0] HC_STAT_IMPL = ev_spread('1);
    localparam logic [HC_DW-1:0] HC_GATE_BIT  = HC_DW'(1) << HC_GATE_POS;
    localparam logic [HC_DW-1:0] HC_MASK_IMPL = HC_STAT_IMPL | HC_GATE_BIT;

endpackage

// File: rtl/hc_irq_status.sv
module hc_irq_status
    import hc_irq_pkg::*;
#(
    parameter int DW  = HC_DW,
    parameter int NEV = HC_NUM_EV
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NEV-1:0] ev_pulse,
    input  logic           ack_we,
    input  logic [DW-1:0]  ack_data,
    output logic [DW-1:0]  stat_q
);

    typedef struct packed {
        logic [DW-1:0] stat;
    } stat_st_t;

    stat_st_t st_d, st_q;
    logic [DW-1:0] ev_vec;

    always_comb begin
        ev_vec = '0;
        for (int i = 0; i < NEV; i++) begin
            ev_vec[ev_bit_pos(i)] = ev_pulse[i];
        end
    end

    always_comb begin
        st_d = st_q;
        if (ack_we) begin
            st_d.stat = st_d.stat & ~ack_data;
        end
        // events applied after the clear so a collision keeps the bit
        st_d.stat = (st_d.stat | ev_vec) & HC_STAT_IMPL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_q = st_q.stat;

endmodule

// File: rtl/hc_irq_mask.sv
module hc_irq_mask
    import hc_irq_pkg::*;
#(
    parameter int DW = HC_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_we,
    input  logic          clr_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] mask_q
);

    typedef struct packed {
        logic [DW-1:0] mask;
    } mask_st_t;

    mask_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_we) begin
            st_d.mask = (st_d.mask | wdata) & HC_MASK_IMPL;
        end
        if (clr_we) begin
            st_d.mask = st_d.mask & ~wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask <= HC_GATE_BIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_q = st_q.mask;

endmodule

// File: rtl/hc_irq_line.sv
module hc_irq_line
    import hc_irq_pkg::*;
#(
    parameter int DW      = HC_DW,
    parameter int GATE_AT = HC_GATE_POS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] stat,
    input  logic [DW-1:0] mask,
    output logic          irq
);

    typedef struct packed {
        logic lvl;
    } line_st_t;

    line_st_t st_d, st_q;

    always_comb begin
        st_d.lvl = mask[GATE_AT] && (|(stat & mask));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.lvl;

endmodule

// File: rtl/hc_irq_unit.sv
module hc_irq_unit
    import hc_irq_pkg::*;
#(
    parameter int DW  = HC_DW,
    parameter int AW  = HC_AW,
    parameter int NEV = HC_NUM_EV
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_sel,
    input  logic           reg_wr,
    input  logic [AW-1:0]  reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    input  logic [NEV-1:0] ev_pulse,
    output logic           irq
);

    logic          wr_go;
    logic          ack_we;
    logic          set_we;
    logic          clr_we;
    logic [DW-1:0] stat_q;
    logic [DW-1:0] mask_q;

    assign wr_go  = reg_sel && reg_wr;
    assign ack_we = wr_go && (reg_addr == HC_A_STATUS);
    assign set_we = wr_go && (reg_addr == HC_A_EN_SET);
    assign clr_we = wr_go && (reg_addr == HC_A_EN_CLR);

    hc_irq_status #(.DW(DW), .NEV(NEV)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_pulse (ev_pulse),
        .ack_we   (ack_we),
        .ack_data (reg_wdata),
        .stat_q   (stat_q)
    );

    hc_irq_mask #(.DW(DW)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (set_we),
        .clr_we (clr_we),
        .wdata  (reg_wdata),
        .mask_q (mask_q)
    );

    hc_irq_line #(.DW(DW), .GATE_AT(HC_GATE_POS)) u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .stat  (stat_q),
        .mask  (mask_q),
        .irq   (irq)
    );

    always_comb begin
        case (reg_addr)
            HC_A_STATUS: reg_rdata = stat_q;
            HC_A_EN_SET,
            HC_A_EN_CLR: reg_rdata = mask_q;
            default:     reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/hc_irq_checker.sv
module hc_irq_checker
    import hc_irq_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_sel,
    input logic                 reg_wr,
    input logic [HC_AW-1:0]     reg_addr,
    input logic [HC_DW-1:0]     reg_wdata,
    input logic [HC_NUM_EV-1:0] ev_pulse,
    input logic [HC_DW-1:0]     stat_q,
    input logic [HC_DW-1:0]     mask_q,
    input logic                 irq
);

    logic w_stat, w_set, w_clr;
    assign w_stat = reg_sel && reg_wr && (reg_addr == HC_A_STATUS);
    assign w_set  = reg_sel && reg_wr && (reg_addr == HC_A_EN_SET);
    assign w_clr  = reg_sel && reg_wr && (reg_addr == HC_A_EN_CLR);

    a_r1_reset_state: assert property (@(posedge clk)
        $rose(rst_n) |-> (stat_q == '0 && mask_q == HC_GATE_BIT && !irq));

    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_pulse) |=> ((stat_q & $past(ev_spread(ev_pulse))) == $past(ev_spread(ev_pulse))));

    a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (w_stat && ev_pulse == '0) |=> ((stat_q & $past(reg_wdata)) == '0));

    a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (w_stat && |(ev_spread(ev_pulse) & reg_wdata))
        |=> ((stat_q & $past(ev_spread(ev_pulse))) == $past(ev_spread(ev_pulse))));

    a_r5_set_ors: assert property (@(posedge clk) disable iff (!rst_n)
        w_set |=> ((mask_q & $past(reg_wdata & HC_MASK_IMPL)) == $past(reg_wdata & HC_MASK_IMPL)));

    a_r6_clr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        w_clr |=> ((mask_q & $past(reg_wdata)) == '0));

    a_r8_line_delay: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(mask_q[HC_GATE_POS] && (|(stat_q & mask_q)))));

    a_r9_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & ~HC_STAT_IMPL) == '0) && ((mask_q & ~HC_MASK_IMPL) == '0));

    a_r10_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_q[HC_GATE_POS] |=> !irq);

endmodule

bind hc_irq_unit hc_irq_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .ev_pulse  (ev_pulse),
    .stat_q    (stat_q),
    .mask_q    (mask_q),
    .irq       (irq)
);

// File: tb/hc_irq_unit_bench.sv
module hc_irq_unit_bench;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  ev_pulse = '0;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];

    always #2 clk = ~clk;

    hc_irq_unit u_hc_irq_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ev_pulse  (ev_pulse),
        .irq       (irq)
    );

    // monitor: compares queued expectations shortly after they are pushed
    initial begin
        forever begin
            wait (sb_q.size() != 0);
            #0.2;
            while (sb_q.size() != 0) begin
                item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                act = it.is_irq ? {31'd0, irq} : reg_rdata;
                n_run++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic push_wait(input bit is_irq, input logic [31:0] exp, input string tag);
        item_t it;
        it.is_irq = is_irq;
        it.exp    = exp;
        it.tag    = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic chk_rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        push_wait(1'b0, exp, tag);
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        push_wait(1'b1, {31'd0, exp}, tag);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [7:0] ev);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d; ev_pulse = ev;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0; ev_pulse = '0;
    endtask

    task automatic pulse(input logic [7:0] ev);
        @(negedge clk);
        ev_pulse = ev;
        @(negedge clk);
        ev_pulse = '0;
    endtask

    initial begin
        #200000;
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] exp_stat;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_rd(2'd0, 32'h0000_0000, "R1 status");
        chk_rd(2'd1, 32'h8000_0000, "R1 mask");
        chk_irq(1'b0, "R1 irq");
        // R7 clear alias reads mask
        chk_rd(2'd2, 32'h8000_0000, "R7 clear alias");

        // R2 each event index sets its bit
        exp_stat = '0;
        for (int i = 0; i < 8; i++) begin
            pulse(8'(1) << i);
            exp_stat[(i == 7) ? 30 : i] = 1'b1;
            chk_rd(2'd0, exp_stat, "R2 event bit");
        end
        chk_irq(1'b0, "R8 no enabled bit");

        // R9 spare address
        wr(2'd3, 32'hFFFF_FFFF, 8'h00);
        chk_rd(2'd3, 32'h0, "R9 spare reads zero");
        chk_rd(2'd0, 32'h4000_007F, "R9 spare write no effect");
        chk_rd(2'd1, 32'h8000_0000, "R9 spare write mask untouched");

        // R3 write-one-to-clear
        wr(2'd0, 32'h0000_0005, 8'h00);
        chk_rd(2'd0, 32'h4000_007A, "R3 clear ones");
        wr(2'd0, 32'h0000_0000, 8'h00);
        chk_rd(2'd0, 32'h4000_007A, "R3 zeros keep");

        // R5 set, R8 one-cycle latency
        wr(2'd1, 32'h0000_0002, 8'h00);
        chk_irq(1'b0, "R8 irq not yet");
        chk_rd(2'd1, 32'h8000_0002, "R5 set ors");
        chk_irq(1'b1, "R8 irq raised");

        // R10 gate clear
        wr(2'd2, 32'h8000_0000, 8'h00);
        chk_irq(1'b1, "R8 irq holds one cycle");
        chk_rd(2'd2, 32'h0000_0002, "R6 gate cleared");
        chk_irq(1'b0, "R10 gate blocks");

        // R6 clear enable bit
        wr(2'd1, 32'h8000_0000, 8'h00);
        chk_rd(2'd1, 32'h8000_0002, "R5 gate set back");
        chk_irq(1'b1, "R8 irq with gate");
        wr(2'd2, 32'h0000_0002, 8'h00);
        chk_rd(2'd1, 32'h8000_0000, "R6 enable cleared");
        chk_irq(1'b0, "R6 irq dropped");

        // R4 collision: event and clear on bit 2
        wr(2'd1, 32'h0000_0004, 8'h00);
        wr(2'd0, 32'h0000_0004, 8'h04);
        chk_rd(2'd0, 32'h4000_007E, "R4 event wins");
        chk_irq(1'b1, "R4 irq from collided bit");

        // R9 unimplemented mask bits
        wr(2'd1, 32'hFFFF_FFFF, 8'h00);
        chk_rd(2'd2, 32'hC000_007F, "R9 mask unused zero");

        // clear everything
        wr(2'd0, 32'hFFFF_FFFF, 8'h00);
        chk_irq(1'b1, "R8 irq before drop");
        chk_rd(2'd0, 32'h0000_0000, "R3 clear all");
        chk_irq(1'b0, "R8 irq after clear");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule